// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block sends stereo PCM samples out over a three-wire serial audio link: a bit clock, a word-select (left/right) clock and a data line. It is always the clock master. Both serial clocks are derived from a root audio clock, which reaches the block as a one-cycle enable strobe in the system clock domain. Software picks two ratios: root strobes per frame and bit clocks per frame. It also picks the sample width, the framing (standard I2S, left-justified or right-justified) and whether the word-select level is inverted.

Samples enter through a write port into a transmit FIFO, one channel per entry, with the left channel first. Software controls the block through a small register port. It starts and stops shifting with an active bit and a pause bit, empties the FIFO with a flush bit, reads the FIFO occupancy and a full flag, and clears a sticky underrun flag that is set when the serializer finds the FIFO empty.

Top module: `i2s_tx_top`

## Requirements
- R1: Register 1, bits 9:0, sets the root strobes per frame. Accepted values are 384, 512 and 768; any other written value selects 256. Each half bit-clock period lasts root/(2·bits) root strobes. The bit clock is low in the first half of each bit and high in the second half. Data and word-select change only while the bit clock is low.
- R2: Register 2, bits 5:0, sets the bit clocks per frame: 16, 24, 32 or 48. A write of any other value leaves the setting unchanged.
- R3: Register 3, bits 5:0, sets the sample width: 8, 16 or 24. A write of any other value is ignored. A FIFO word carries its sample right-aligned, and bits above the width are not sent.
- R4: Format code 0 (standard) drives word-select low for the left slot and high for the right slot. Word-select changes one bit clock before the MSB of the slot goes out.
- R5: Format code 1 (left-justified) drives word-select high for the left slot and low for the right slot. The MSB goes out in the first bit of the slot.
- R6: Format code 2 (right-justified) uses the word-select levels of R5. The sample is placed so that its LSB is the last bit of the slot.
- R7: Register 4, bit 2, inverts the word-select level of every format. A write of format code 3 to bits 1:0 is ignored, together with its bit 2.
- R8: Each slot is half a frame. The left slot is first. Each slot consumes one FIFO entry, and slot bits outside the sample are driven low.
- R9: Shifting runs while register 0 bit 0 (active) is 1 and bit 1 (pause) is 0. While stopped, the bit clock and data are low, FIFO contents are kept, and a restart begins with a left slot.
- R10: While register 5 bit 7 (flush) is 1, the FIFO is held empty. Register 5 bits 14:8 read the FIFO occupancy.
- R11: Register 0 bit 2 reads 1 when the FIFO holds FIFO_DEPTH entries. A sample written while it is full is dropped.
- R12: A slot that starts with the FIFO empty is sent as zeros and sets register 0 bit 3. The bit stays set until a register 0 write with bit 3 at 1.
- R13: After reset, registers 0 to 5 read 0, 256, 32, 16, 0 and 0, and the bit clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| root_en | input | 1 | One strobe per root audio clock period |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index 0..5 |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for cfg_addr |
| smp_we | input | 1 | Sample write strobe into the FIFO |
| smp_data | input | 24 | Right-aligned sample |
| bclk_o | output | 1 | Serial bit clock |
| lrclk_o | output | 1 | Word-select clock |
| sd_o | output | 1 | Serial data |

## Verification
The assertions assume that the ratios, width and format change only while shifting is stopped. They also assume that the chosen root and bit ratios divide evenly, so that the bit clock period stays fixed across a frame. The stimulus rewrites configuration only after clearing the active bit, and uses only root/bit pairs whose quotient is an even whole number. It stops or pauses at least two system cycles before the next slot would fetch from the FIFO, which keeps unwanted underruns out of the recorded frames.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    localparam int SAMPLE_W = 24;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_ROOT  = 3'd1;
    localparam logic [2:0] A_BITS  = 3'd2;
    localparam logic [2:0] A_WIDTH = 3'd3;
    localparam logic [2:0] A_FMT   = 3'd4;
    localparam logic [2:0] A_FIFO  = 3'd5;

    localparam int CTRL_ACT   = 0;
    localparam int CTRL_PAUSE = 1;
    localparam int CTRL_UNDR  = 3;
    localparam int FIFO_FLUSH = 7;

    typedef enum logic [1:0] {FMT_I2S = 2'd0, FMT_LEFT = 2'd1, FMT_RIGHT = 2'd2} fmt_e;
    typedef enum logic [1:0] {RR_256, RR_384, RR_512, RR_768} root_e;
    typedef enum logic [1:0] {BR_16, BR_24, BR_32, BR_48} bck_e;
    typedef enum logic [1:0] {SW_8, SW_16, SW_24} width_e;

    typedef struct packed {
        root_e  root;
        bck_e   bck;
        width_e width;
        fmt_e   fmt;
        logic   inv;
    } cfg_t;

    typedef struct packed {
        logic ok;
        bck_e code;
    } bck_dec_t;

    typedef struct packed {
        logic   ok;
        width_e code;
    } width_dec_t;

    function automatic logic [9:0] root_val(root_e r);
        case (r)
            RR_384:  return 10'd384;
            RR_512:  return 10'd512;
            RR_768:  return 10'd768;
            default: return 10'd256;
        endcase
    endfunction

    function automatic root_e root_decode(logic [9:0] v);
        case (v)
            10'd384: return RR_384;
            10'd512: return RR_512;
            10'd768: return RR_768;
            default: return RR_256;
        endcase
    endfunction

    function automatic logic [5:0] bck_val(bck_e b);
        case (b)
            BR_16:   return 6'd16;
            BR_24:   return 6'd24;
            BR_48:   return 6'd48;
            default: return 6'd32;
        endcase
    endfunction

    function automatic bck_dec_t bck_decode(logic [5:0] v);
        case (v)
            6'd16:   return '{ok: 1'b1, code: BR_16};
            6'd24:   return '{ok: 1'b1, code: BR_24};
            6'd32:   return '{ok: 1'b1, code: BR_32};
            6'd48:   return '{ok: 1'b1, code: BR_48};
            default: return '{ok: 1'b0, code: BR_32};
        endcase
    endfunction

    function automatic logic [5:0] width_val(width_e w);
        case (w)
            SW_8:    return 6'd8;
            SW_24:   return 6'd24;
            default: return 6'd16;
        endcase
    endfunction

    function automatic width_dec_t width_decode(logic [5:0] v);
        case (v)
            6'd8:    return '{ok: 1'b1, code: SW_8};
            6'd16:   return '{ok: 1'b1, code: SW_16};
            6'd24:   return '{ok: 1'b1, code: SW_24};
            default: return '{ok: 1'b0, code: SW_16};
        endcase
    endfunction

    // Root strobes per half bit-clock period.
    function automatic logic [4:0] half_ticks(root_e r, bck_e b);
        return 5'(root_val(r) / (10'(bck_val(b)) << 1));
    endfunction

    // Data bit for slot position k; samples are right-aligned in s.
    function automatic logic bit_at(logic [SAMPLE_W-1:0] s, logic [5:0] w,
                                    logic [5:0] slot, logic [5:0] k, fmt_e f);
        int p;
        p = int'(k);
        if (f == FMT_RIGHT)
            p = int'(k) - (int'(slot) - int'(w));
        if (p >= 0 && p < int'(w))
            return s[5'(int'(w) - 1 - p)];
        return 1'b0;
    endfunction

    function automatic logic ws_level(logic right, fmt_e f, logic inv);
        return right ^ (f != FMT_I2S) ^ inv;
    endfunction

endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 24,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_wr, do_rd;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_wr   = wr_en && !full && !flush;
    assign do_rd   = rd_en && !empty && !flush;
    assign rd_data = mem[rd_ptr];

    function automatic logic [AW-1:0] step(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr)
                wr_ptr <= step(wr_ptr);
            if (do_rd)
                rd_ptr <= step(rd_ptr);
            count <= count + CW'(do_wr) - CW'(do_rd);
        end
    end
endmodule

// File: rtl/i2s_tx_cfg.sv
module i2s_tx_cfg
    import i2s_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata,
    input  logic        fifo_full,
    input  logic [6:0]  fifo_level,
    input  logic        underrun_set,
    output cfg_t        cfg,
    output logic        run,
    output logic        flush,
    output logic        underrun
);
    logic       active, pause;
    bck_dec_t   bdec;
    width_dec_t wdec;
    logic       unused_bits;

    assign bdec        = bck_decode(cfg_wdata[5:0]);
    assign wdec        = width_decode(cfg_wdata[5:0]);
    assign run         = active && !pause;
    assign unused_bits = ^cfg_wdata[15:10];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '{root: RR_256, bck: BR_32, width: SW_16, fmt: FMT_I2S, inv: 1'b0};
            active   <= 1'b0;
            pause    <= 1'b0;
            flush    <= 1'b0;
            underrun <= 1'b0;
        end else begin
            if (underrun_set)
                underrun <= 1'b1;
            else if (cfg_we && cfg_addr == A_CTRL && cfg_wdata[CTRL_UNDR])
                underrun <= 1'b0;
            if (cfg_we) begin
                case (cfg_addr)
                    A_CTRL: begin
                        active <= cfg_wdata[CTRL_ACT];
                        pause  <= cfg_wdata[CTRL_PAUSE];
                    end
                    A_ROOT:  cfg.root <= root_decode(cfg_wdata[9:0]);
                    A_BITS:  if (bdec.ok) cfg.bck <= bdec.code;
                    A_WIDTH: if (wdec.ok) cfg.width <= wdec.code;
                    A_FMT: begin
                        if (cfg_wdata[1:0] != 2'd3) begin
                            cfg.fmt <= fmt_e'(cfg_wdata[1:0]);
                            cfg.inv <= cfg_wdata[2];
                        end
                    end
                    A_FIFO:  flush <= cfg_wdata[FIFO_FLUSH];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (cfg_addr)
            A_CTRL:  cfg_rdata = {12'd0, underrun, fifo_full, pause, active};
            A_ROOT:  cfg_rdata = {6'd0, root_val(cfg.root)};
            A_BITS:  cfg_rdata = {10'd0, bck_val(cfg.bck)};
            A_WIDTH: cfg_rdata = {10'd0, width_val(cfg.width)};
            A_FMT:   cfg_rdata = {13'd0, cfg.inv, cfg.fmt};
            A_FIFO:  cfg_rdata = {1'b0, fifo_level, flush, 7'd0};
            default: cfg_rdata = 16'd0;
        endcase
    end
endmodule

// File: rtl/i2s_tx_serdes.sv
module i2s_tx_serdes
    import i2s_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                root_en,
    input  logic                run,
    input  cfg_t                cfg,
    input  logic                fifo_empty,
    input  logic [SAMPLE_W-1:0] fifo_data,
    output logic                fifo_pop,
    output logic                underrun_set,
    output logic                bclk_o,
    output logic                lrclk_o,
    output logic                sd_o
);
    logic [4:0]          hcnt, half;
    logic                phase;
    logic [5:0]          g, g_next, g_lead, nbits, nslot, nwidth, k_next;
    logic [SAMPLE_W-1:0] sample, smp_next;
    logic                last_half, advance, new_slot, chan_next, chan_lead, ws_chan;

    assign nbits     = bck_val(cfg.bck);
    assign nslot     = nbits >> 1;
    assign nwidth    = width_val(cfg.width);
    assign half      = half_ticks(cfg.root, cfg.bck);
    assign last_half = (hcnt == half - 5'd1);
    assign advance   = run && root_en && last_half && phase;

    assign g_next    = (g == nbits - 6'd1) ? 6'd0 : g + 6'd1;
    assign g_lead    = (g_next == nbits - 6'd1) ? 6'd0 : g_next + 6'd1;
    assign new_slot  = (g_next == 6'd0) || (g_next == nslot);
    assign chan_next = (g_next >= nslot);
    assign chan_lead = (g_lead >= nslot);
    assign ws_chan   = (cfg.fmt == FMT_I2S) ? chan_lead : chan_next;
    assign k_next    = chan_next ? g_next - nslot : g_next;

    assign fifo_pop     = advance && new_slot && !fifo_empty;
    assign underrun_set = advance && new_slot && fifo_empty;
    assign smp_next     = !new_slot ? sample : (fifo_empty ? '0 : fifo_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt    <= '0;
            phase   <= 1'b1;
            g       <= '0;
            sample  <= '0;
            bclk_o  <= 1'b0;
            lrclk_o <= 1'b0;
            sd_o    <= 1'b0;
        end else if (!run) begin
            hcnt   <= half - 5'd1;
            phase  <= 1'b1;
            g      <= nbits - 6'd1;
            bclk_o <= 1'b0;
            sd_o   <= 1'b0;
        end else if (root_en) begin
            if (!last_half) begin
                hcnt <= hcnt + 5'd1;
            end else begin
                hcnt <= '0;
                if (!phase) begin
                    phase  <= 1'b1;
                    bclk_o <= 1'b1;
                end else begin
                    phase   <= 1'b0;
                    bclk_o  <= 1'b0;
                    g       <= g_next;
                    sample  <= smp_next;
                    sd_o    <= bit_at(smp_next, nwidth, nslot, k_next, cfg.fmt);
                    lrclk_o <= ws_level(ws_chan, cfg.fmt, cfg.inv);
                end
            end
        end
    end
endmodule

// File: rtl/i2s_tx_top.sv
module i2s_tx_top
    import i2s_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                root_en,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_addr,
    input  logic [15:0]         cfg_wdata,
    output logic [15:0]         cfg_rdata,
    input  logic                smp_we,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                bclk_o,
    output logic                lrclk_o,
    output logic                sd_o
);
    cfg_t                cfg;
    logic                run, flush, underrun, underrun_set;
    logic                fifo_pop, fifo_full, fifo_empty;
    logic [CNT_W-1:0]    fifo_count;
    logic [6:0]          fifo_level;
    logic [SAMPLE_W-1:0] fifo_data;

    assign fifo_level = 7'(fifo_count);

    i2s_tx_cfg u_cfg (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .fifo_full    (fifo_full),
        .fifo_level   (fifo_level),
        .underrun_set (underrun_set),
        .cfg          (cfg),
        .run          (run),
        .flush        (flush),
        .underrun     (underrun)
    );

    i2s_tx_fifo #(.DEPTH(FIFO_DEPTH), .DW(SAMPLE_W)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .wr_en   (smp_we),
        .wr_data (smp_data),
        .rd_en   (fifo_pop),
        .rd_data (fifo_data),
        .count   (fifo_count),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    i2s_tx_serdes u_ser (
        .clk          (clk),
        .rst          (rst),
        .root_en      (root_en),
        .run          (run),
        .cfg          (cfg),
        .fifo_empty   (fifo_empty),
        .fifo_data    (fifo_data),
        .fifo_pop     (fifo_pop),
        .underrun_set (underrun_set),
        .bclk_o       (bclk_o),
        .lrclk_o      (lrclk_o),
        .sd_o         (sd_o)
    );
endmodule

// File: rtl/i2s_tx_chk.sv
module i2s_tx_chk
    import i2s_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             root_en,
    input logic             run,
    input logic             cfg_we,
    input logic [2:0]       cfg_addr,
    input logic [15:0]      cfg_wdata,
    input logic             smp_we,
    input logic             fifo_pop,
    input logic             fifo_full,
    input logic [CNT_W-1:0] fifo_count,
    input logic             flush,
    input logic             underrun,
    input logic             bclk_o,
    input logic             lrclk_o,
    input logic             sd_o
);
    logic undr_clear;
    assign undr_clear = cfg_we && (cfg_addr == A_CTRL) && cfg_wdata[CTRL_UNDR];

    assert_count_bound_R11: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CNT_W'(DEPTH));

    assert_full_drop_R11: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && smp_we && !fifo_pop && !flush) |=> fifo_count == $past(fifo_count));

    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> fifo_count == '0);

    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !run |=> !bclk_o && !sd_o);

    assert_sticky_underrun_R12: assert property (@(posedge clk) disable iff (rst)
        (underrun && !undr_clear) |=> underrun);

    assert_data_on_low_R1: assert property (@(posedge clk) disable iff (rst)
        !$stable(sd_o) |-> !bclk_o);

    assert_ws_on_low_R1: assert property (@(posedge clk) disable iff (rst)
        !$stable(lrclk_o) |-> !bclk_o);

    assert_root_paced_R1: assert property (@(posedge clk) disable iff (rst)
        (run && !root_en) |=> $stable(bclk_o));
endmodule

bind i2s_tx_top i2s_tx_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .root_en    (root_en),
    .run        (run),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .smp_we     (smp_we),
    .fifo_pop   (fifo_pop),
    .fifo_full  (fifo_full),
    .fifo_count (fifo_count),
    .flush      (flush),
    .underrun   (underrun),
    .bclk_o     (bclk_o),
    .lrclk_o    (lrclk_o),
    .sd_o       (sd_o)
);

// File: tb/tb_i2s_tx_top.sv
`timescale 1ns/1ps
module tb_i2s_tx_top;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        root_en = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;
    logic        smp_we = 1'b0;
    logic [23:0] smp_data = 24'd0;
    logic        bclk_o, lrclk_o, sd_o;

    i2s_tx_top #(.FIFO_DEPTH(DEPTH)) dut (.*);

    always #4 clk = ~clk;

    int  nchk = 0, nfail = 0;
    int  cyc = 0, last_rise = 0, period = 0, ncap = 0;
    bit  slow = 1'b0;
    logic prev_bclk = 1'b0;
    logic cap_sd [128];
    logic cap_lr [128];

    // root strobe: every cycle, or every other cycle in slow mode
    always @(negedge clk) root_en <= slow ? ~root_en : 1'b1;

    // record data and word-select at each rising bit clock
    always @(negedge clk) begin
        cyc <= cyc + 1;
        prev_bclk <= bclk_o;
        if (bclk_o && !prev_bclk) begin
            if (ncap < 128) begin
                cap_sd[ncap] = sd_o;
                cap_lr[ncap] = lrclk_o;
            end
            period = cyc - last_rise;
            last_rise = cyc;
            ncap = ncap + 1;
        end
    end

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic push(logic [23:0] d);
        @(negedge clk);
        smp_we = 1'b1; smp_data = d;
        @(negedge clk);
        smp_we = 1'b0;
    endtask

    // capture n bits after starting, then stop (ctrl value stopv) at once
    task automatic run_bits(int n, logic [15:0] stopv);
        ncap = 0;
        wr(3'd0, 16'h0001);
        while (ncap < n) @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = stopv;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic exp_sd(int g, int nb, int w, int fmt, logic [23:0] l, logic [23:0] r);
        int s = nb / 2;
        int ch = (g >= s) ? 1 : 0;
        int k = ch ? g - s : g;
        int p = (fmt == 2) ? k - (s - w) : k;
        logic [23:0] smp = ch ? r : l;
        if (p >= 0 && p < w) return smp[w - 1 - p];
        return 1'b0;
    endfunction

    function automatic logic exp_lr(int g, int nb, int fmt, logic inv);
        int s = nb / 2;
        int gg = (fmt == 0) ? (g + 1) % nb : g;
        return ((gg >= s) ? 1'b1 : 1'b0) ^ (fmt != 0) ^ inv;
    endfunction

    task automatic cmp_frame(string tag, int nb, int w, int fmt, logic inv, logic [23:0] l, logic [23:0] r);
        logic [63:0] a_sd = '0, e_sd = '0, a_lr = '0, e_lr = '0;
        for (int g = 0; g < nb; g++) begin
            a_sd[g] = cap_sd[g]; e_sd[g] = exp_sd(g, nb, w, fmt, l, r);
            a_lr[g] = cap_lr[g]; e_lr[g] = exp_lr(g, nb, fmt, inv);
        end
        check(tag, "data bits", a_sd, e_sd);
        check(tag, "word-select", a_lr, e_lr);
    endtask

    // root, bits, width, fmt, inv, left, right
    localparam logic [71:0] VEC [8] = '{
        {10'd256, 6'd32, 5'd16, 2'd0, 1'b0, 24'h00A5C3, 24'h001234},
        {10'd384, 6'd48, 5'd24, 2'd0, 1'b0, 24'h800001, 24'h7F00FE},
        {10'd512, 6'd32, 5'd16, 2'd1, 1'b0, 24'h00F00D, 24'h008001},
        {10'd256, 6'd32, 5'd8,  2'd2, 1'b0, 24'hFF3C5A, 24'h0000C3},
        {10'd768, 6'd48, 5'd16, 2'd2, 1'b1, 24'h00BEEF, 24'h000F0F},
        {10'd256, 6'd16, 5'd8,  2'd1, 1'b1, 24'h000096, 24'h000069},
        {10'd384, 6'd24, 5'd8,  2'd0, 1'b1, 24'h0000E1, 24'h00001E},
        {10'd512, 6'd16, 5'd8,  2'd2, 1'b0, 24'h000081, 24'h00007E}
    };

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13 reset state
        rd(3'd0, d); check("R13", "ctrl", d, 16'd0);
        rd(3'd1, d); check("R13", "root", d, 16'd256);
        rd(3'd2, d); check("R13", "bits", d, 16'd32);
        rd(3'd3, d); check("R13", "width", d, 16'd16);
        rd(3'd4, d); check("R13", "format", d, 16'd0);
        rd(3'd5, d); check("R13", "fifo", d, 16'd0);
        check("R13", "bclk idle", bclk_o, 1'b0);

        // table of framing vectors
        for (int i = 0; i < 8; i++) begin
            logic [71:0] v = VEC[i];
            int nb = int'(v[61:56]);
            int w = int'(v[55:51]);
            int fmt = int'(v[50:49]);
            int half = int'(v[71:62]) / (2 * nb);
            string tag = (fmt == 0) ? "R4" : (fmt == 1) ? "R5" : "R6";
            wr(3'd0, 16'h0008);
            wr(3'd1, {6'd0, v[71:62]});
            wr(3'd2, {10'd0, v[61:56]});
            wr(3'd3, {11'd0, v[55:51]});
            wr(3'd4, {13'd0, v[48], v[50:49]});
            rd(3'd1, d); check("R1", "root readback", d, {6'd0, v[71:62]});
            push(v[47:24]);
            push(v[23:0]);
            run_bits(nb, 16'h0000);
            cmp_frame(tag, nb, w, fmt, v[48], v[47:24], v[23:0]);
            check("R1", "bit period", period, 2 * half);
            rd(3'd5, d); check("R8", "one entry per slot", d[14:8], 7'd0);
            rd(3'd0, d); check("R12", "no false underrun", d[3], 1'b0);
        end

        // R1 unsupported root ratio falls back to 256
        wr(3'd1, 16'd512); wr(3'd1, 16'd300);
        rd(3'd1, d); check("R1", "root fallback", d, 16'd256);
        // R2 unsupported bit ratio keeps previous
        wr(3'd2, 16'd24); wr(3'd2, 16'd20);
        rd(3'd2, d); check("R2", "bits kept", d, 16'd24);
        // R3 unsupported width keeps previous
        wr(3'd3, 16'd24); wr(3'd3, 16'd12);
        rd(3'd3, d); check("R3", "width kept", d, 16'd24);
        // R7 format code 3 ignored
        wr(3'd4, 16'd6); wr(3'd4, 16'd3);
        rd(3'd4, d); check("R7", "format kept", d, 16'd6);

        // R11 full flag and dropped write
        for (int i = 0; i < DEPTH; i++) push(24'(i));
        rd(3'd5, d); check("R11", "count at full", d[14:8], 7'(DEPTH));
        rd(3'd0, d); check("R11", "full flag", d[2], 1'b1);
        push(24'h00ABCD);
        rd(3'd5, d); check("R11", "write while full dropped", d[14:8], 7'(DEPTH));
        // R10 flush
        wr(3'd5, 16'h0080);
        rd(3'd5, d); check("R10", "flush held", d, 16'h0080);
        push(24'h000011);
        rd(3'd5, d); check("R10", "write during flush", d[14:8], 7'd0);
        wr(3'd5, 16'h0000);
        push(24'h000011);
        rd(3'd5, d); check("R10", "after flush release", d[14:8], 7'd1);
        wr(3'd5, 16'h0080); wr(3'd5, 16'h0000);

        // R9 pause keeps FIFO, resume starts at left slot
        wr(3'd1, 16'd256); wr(3'd2, 16'd32); wr(3'd3, 16'd16); wr(3'd4, 16'd0);
        push(24'h001111); push(24'h002222); push(24'h00C0DE); push(24'h00ACE5);
        run_bits(32, 16'h0003);
        ncap = 0;
        repeat (200) @(negedge clk);
        check("R9", "no bit clock while paused", ncap, 0);
        check("R9", "data low while paused", sd_o, 1'b0);
        rd(3'd5, d); check("R9", "fifo kept", d[14:8], 7'd2);
        run_bits(32, 16'h0000);
        cmp_frame("R9", 32, 16, 0, 1'b0, 24'h00C0DE, 24'h00ACE5);

        // R1 slower root strobe
        slow = 1'b1;
        push(24'h005A5A); push(24'h00A5A5);
        run_bits(32, 16'h0000);
        check("R1", "period with half-rate strobe", period, 16);
        cmp_frame("R4", 32, 16, 0, 1'b0, 24'h005A5A, 24'h00A5A5);
        slow = 1'b0;

        // R12 underrun sends zeros, sticky until cleared
        wr(3'd0, 16'h0008);
        run_bits(32, 16'h0000);
        cmp_frame("R12", 32, 16, 0, 1'b0, 24'h0, 24'h0);
        repeat (20) @(negedge clk);
        rd(3'd0, d); check("R12", "underrun sticky", d[3], 1'b1);
        wr(3'd0, 16'h0008);
        rd(3'd0, d); check("R12", "underrun cleared", d[3], 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule